// File: doc/BRIEF.md
# Decimal Digit Writer

This unit takes an unsigned 8-bit value and stores its decimal form in byte memory as three separate digit bytes. After a single-cycle start request it converts the value to decimal with an iterative shift-and-add-three loop. It then puts the three digits onto a write port, one byte per cycle, most significant digit first, at a 12-bit base address and the two addresses after it. A one-cycle done pulse closes each operation.

The host drives `start` together with `value` and `base`. It then watches the write port, which has no backpressure, and waits for `done`. While an operation is in flight the unit takes no new request. The base pointer the host supplies is copied and never changed by the unit.

Top module: `dstore_bcd_unit`

## Requirements
- R1: The three bytes written hold the hundreds, tens and ones digits of `value`, each in the range 0 to 9. For example, 255 gives 2,5,5; 99 gives 0,9,9; 1 gives 0,0,1.
- R2: The hundreds digit goes to `base`, the tens digit to `base`+1 and the ones digit to `base`+2. The three writes fall on three consecutive cycles in that order.
- R3: Every written byte has its digit in bits 3:0 and zero in bits 7:4.
- R4: Address arithmetic is modulo 4096. A base of 0xFFE writes to 0xFFE, 0xFFF and 0x000.
- R5: `done` is high for exactly one cycle. That cycle comes right after the third write, and `wr_valid` is low in it.
- R6: A `start` sampled from the cycle after acceptance up to and including the `done` cycle is ignored. It does not change the digits, the addresses or the number of writes.
- R7: While `rst` is high, `wr_valid` and `done` are low.
- R8: `wr_valid` first goes high after the 9th rising edge following the edge that samples `start`. That is the conversion width plus one.
- R9: Each accepted `start` produces exactly three writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, taken only when the unit is idle |
| value | input | 8 | Unsigned value to convert, sampled with start |
| base | input | 12 | Address for the hundreds digit, sampled with start |
| wr_valid | output | 1 | Write strobe, one byte per cycle |
| wr_addr | output | 12 | Write address |
| wr_data | output | 8 | Write data: one decimal digit, upper nibble zero |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that `rst` is held for at least one edge before use, and that `value` and `base` matter only in the cycle in which `start` is accepted. They place no limit on when `start` may rise. The stimulus deliberately raises `start` during conversion, during the writes and in the `done` cycle, with different operands each time. Values come from a seeded random source mixed with the digit-boundary cases 0, 9, 10, 99, 100, 199, 200 and 255. Bases include the top of the address space so that the wrap is exercised.

// File: rtl/dstore_pkg.sv
package dstore_pkg;

    localparam int DIG_W  = 4;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 12;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CONV  = 2'd1,
        ST_WRITE = 2'd2,
        ST_DONE  = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } wr_beat_t;

    // number of decimal digits needed for the largest w-bit value
    function automatic int num_digits(input int w);
        longint v;
        int n;
        v = (longint'(1) << w) - 1;
        n = 0;
        while (v > 0) begin
            v = v / 10;
            n++;
        end
        return (n == 0) ? 1 : n;
    endfunction

    // shift-and-add-three correction for one digit
    function automatic logic [DIG_W-1:0] dab_adjust(input logic [DIG_W-1:0] d);
        return (d >= 4'd5) ? d + 4'd3 : d;
    endfunction

endpackage

// File: rtl/dstore_dabble.sv
module dstore_dabble
    import dstore_pkg::*;
#(
    parameter int VAL_W = 8,
    parameter int NDIG  = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic [VAL_W-1:0]      value,
    output logic                  rdy,
    output logic [NDIG*DIG_W-1:0] digits
);
    localparam int BCD_W = NDIG * DIG_W;
    localparam int CNT_W = $clog2(VAL_W + 1);

    logic [VAL_W-1:0] sh_q, sh_n;
    logic [BCD_W-1:0] bcd_q, bcd_n, adj;
    logic [CNT_W-1:0] cnt_q;
    logic             rdy_q;

    for (genvar g = 0; g < NDIG; g++) begin : g_adj
        assign adj[g*DIG_W +: DIG_W] = dab_adjust(bcd_q[g*DIG_W +: DIG_W]);
    end

    assign {bcd_n, sh_n} = {adj[BCD_W-2:0], sh_q, 1'b0};

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            bcd_q <= '0;
            cnt_q <= '0;
            rdy_q <= 1'b0;
        end else begin
            rdy_q <= 1'b0;
            if (load) begin
                sh_q  <= value;
                bcd_q <= '0;
                cnt_q <= CNT_W'(VAL_W);
            end else if (cnt_q != '0) begin
                sh_q  <= sh_n;
                bcd_q <= bcd_n;
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) rdy_q <= 1'b1;
            end
        end
    end

    assign rdy    = rdy_q;
    assign digits = bcd_q;

    // R1: the top digit never carries out during a shift step
    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != '0 && !load) |-> !adj[BCD_W-1]);

    for (genvar g = 0; g < NDIG; g++) begin : g_chk
        // R1: every digit is decimal once conversion finishes
        assert_digit_range_R1: assert property (@(posedge clk) disable iff (rst)
            rdy |-> (digits[g*DIG_W +: DIG_W] <= 4'd9));
    end

endmodule

// File: rtl/dstore_seq.sv
module dstore_seq
    import dstore_pkg::*;
#(
    parameter int NDIG = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [ADDR_W-1:0]     base,
    input  logic                  conv_rdy,
    input  logic [NDIG*DIG_W-1:0] digits,
    output logic                  conv_load,
    output wr_beat_t              beat,
    output logic                  done
);
    localparam int IDX_W = (NDIG > 1) ? $clog2(NDIG) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NDIG - 1);

    seq_state_e        state_q;
    logic [ADDR_W-1:0] base_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DIG_W-1:0]  dig_arr [NDIG];
    logic [DIG_W-1:0]  cur_dig;
    logic [ADDR_W-1:0] addr_inc;

    // most significant digit first
    for (genvar g = 0; g < NDIG; g++) begin : g_sel
        assign dig_arr[g] = digits[(NDIG-1-g)*DIG_W +: DIG_W];
    end

    assign cur_dig   = dig_arr[idx_q];
    assign conv_load = (state_q == ST_IDLE) && start;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            idx_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    base_q  <= base;
                    idx_q   <= '0;
                    state_q <= ST_CONV;
                end
                ST_CONV: if (conv_rdy) state_q <= ST_WRITE;
                ST_WRITE: begin
                    if (idx_q == LAST_IDX) state_q <= ST_DONE;
                    else                   idx_q   <= idx_q + 1'b1;
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        beat.valid = (state_q == ST_WRITE);
        beat.addr  = base_q + ADDR_W'(idx_q);
        beat.data  = {{(BYTE_W-DIG_W){1'b0}}, cur_dig};
    end

    assign done     = (state_q == ST_DONE);
    assign addr_inc = beat.addr + 1'b1;

    // R2 and R4: back-to-back writes step the address by one, wrapping
    assert_addr_step_R2: assert property (@(posedge clk) disable iff (rst)
        (beat.valid && $past(beat.valid)) |-> (beat.addr == $past(addr_inc)));

    // R3: written bytes hold a single decimal digit
    assert_byte_digit_R3: assert property (@(posedge clk) disable iff (rst)
        beat.valid |-> (beat.data <= BYTE_W'(9)));

    // R5: done follows a write and carries none itself
    assert_done_after_write_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(beat.valid) && !beat.valid));

    assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6: the captured base does not move once an operation is under way
    assert_base_held_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |=> $stable(base_q));

    // R9: a write never begins straight from idle
    assert_no_stray_write_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(beat.valid) |-> $past(conv_rdy));

endmodule

// File: rtl/dstore_bcd_unit.sv
module dstore_bcd_unit
    import dstore_pkg::*;
#(
    parameter int VAL_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [VAL_W-1:0]  value,
    input  logic [ADDR_W-1:0] base,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              done
);
    localparam int NDIG = num_digits(VAL_W);

    logic                  conv_load;
    logic                  conv_rdy;
    logic [NDIG*DIG_W-1:0] digits;
    wr_beat_t              beat;

    dstore_dabble #(.VAL_W(VAL_W), .NDIG(NDIG)) u_conv (
        .clk    (clk),
        .rst    (rst),
        .load   (conv_load),
        .value  (value),
        .rdy    (conv_rdy),
        .digits (digits)
    );

    dstore_seq #(.NDIG(NDIG)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .base      (base),
        .conv_rdy  (conv_rdy),
        .digits    (digits),
        .conv_load (conv_load),
        .beat      (beat),
        .done      (done)
    );

    assign wr_valid = beat.valid;
    assign wr_addr  = beat.addr;
    assign wr_data  = beat.data;

    // R7: quiet outputs while in reset
    assert_reset_quiet_R7: assert property (@(posedge clk)
        $past(rst) |-> (!wr_valid && !done));

endmodule

// File: tb/dstore_bcd_unit_tb.sv
module dstore_bcd_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  value = '0;
    logic [11:0] base = '0;
    logic        wr_valid;
    logic [11:0] wr_addr;
    logic [7:0]  wr_data;
    logic        done;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit reported = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    dstore_bcd_unit u_dut (
        .clk(clk), .rst(rst), .start(start), .value(value), .base(base),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .done(done)
    );

    function automatic logic [7:0] exp_digit(input logic [7:0] v, input int k);
        case (k)
            0:       return 8'(v / 100);
            1:       return 8'((v / 10) % 10);
            default: return 8'(v % 10);
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
            report();
            $finish;
        end
    end

    // one operation; poke raises start again mid-flight with other operands
    task automatic run_op(input logic [7:0] v, input logic [11:0] b, input bit poke);
        int nwr = 0;
        int ndone = 0;
        int done_edge = -1;
        int first_edge = -1;
        @(negedge clk);
        start = 1'b1; value = v; base = b;
        @(posedge clk);
        #1;
        start = 1'b0;
        if (poke) begin
            start = 1'b1; value = ~v; base = b + 12'h100;
        end
        for (int e = 1; e <= 24; e++) begin
            @(posedge clk);
            #1;
            start = 1'b0;
            if (wr_valid) begin
                logic [11:0] ea;
                ea = b + 12'(nwr);
                if (nwr == 0) begin
                    first_edge = e;
                    chk(e == 9, "R8", "first write edge", e, 9);
                end
                if (nwr < 3) begin
                    chk(wr_addr == ea, "R2/R4", "write address", int'(wr_addr), int'(ea));
                    chk(wr_data == exp_digit(v, nwr), "R1/R6", "digit byte",
                        int'(wr_data), int'(exp_digit(v, nwr)));
                    chk(wr_data[7:4] == 4'd0, "R3", "upper nibble", int'(wr_data[7:4]), 0);
                    chk(e == first_edge + nwr, "R2", "consecutive writes", e, first_edge + nwr);
                end
                nwr++;
            end
            if (done) begin
                ndone++;
                if (done_edge < 0) done_edge = e;
                chk(!wr_valid, "R5", "write during done", int'(wr_valid), 0);
            end
            if (poke && (e == 10 || e == 12)) begin
                start = 1'b1; value = ~v; base = b + 12'h200;
            end
        end
        chk(nwr == 3, "R9/R6", "write count", nwr, 3);
        chk(ndone == 1, "R5", "done pulse count", ndone, 1);
        chk(done_edge == 12, "R5", "done edge", done_edge, 12);
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) begin
            @(posedge clk);
            #1;
            chk(!wr_valid && !done, "R7", "outputs in reset",
                int'({wr_valid, done}), 0);
        end
        @(negedge clk);
        rst = 1'b0;
        repeat (2) @(posedge clk);

        run_op(8'd255, 12'd0, 1'b0);
        run_op(8'd99,  12'd3, 1'b0);
        run_op(8'd1,   12'd6, 1'b1);
        run_op(8'd0,   12'h040, 1'b0);
        run_op(8'd9,   12'h050, 1'b1);
        run_op(8'd10,  12'h060, 1'b0);
        run_op(8'd100, 12'h070, 1'b1);
        run_op(8'd199, 12'h080, 1'b0);
        run_op(8'd200, 12'h090, 1'b0);
        run_op(8'd255, 12'hFFE, 1'b1);  // R4 wrap
        run_op(8'd128, 12'hFFF, 1'b0);  // R4 wrap
        for (int i = 0; i < 40; i++) begin
            run_op(8'($urandom_range(0, 255)), 12'($urandom_range(0, 4095)),
                   1'($urandom_range(0, 1)));
        end
        report();
        $finish;
    end

endmodule